// File: doc/BRIEF.md
# Multi-Lane Transmit Serializer with Tristate Control

This block turns parallel 8-bit words into serial bit streams on several output lanes. A separate serial tristate enable goes with each lane to its pad buffer. It runs on the bit-rate clock. An internal phase counter splits time into frames of 8, 4 or 2 unit intervals (UI), and one word is taken per lane at the start of each frame. Parallel inputs are held stable for a whole frame and change away from the load edge. `frameStart` marks the first UI of every frame on the serial outputs.

Each lane gets its tristate from one of two sources, chosen by a static per-lane select:

- **Direct source:** the lane's own tristate input, passed straight through with no register.
- **Enable source:** a write-enable vector shared by all lanes. It is inverted and stepped out two UIs per bit. It is delayed one frame more than the data, so it is presented one frame before the word it gates.

An optional preamble UI can be placed ahead of a burst. When a preamble is inserted, the last UI of an idle frame already carries the first bit of the coming word with the driver enabled. This covers a tristate release that reaches the pad late. Selecting the enable source in 2:1 mode is not legal. The block flags this on `cfgErr` and the lane uses its direct source instead.

Top module: `txser_top`

## Requirements
- R1: In 8:1 mode (`ratioSel`=0) each frame is 8 UIs and lane word bits go out in the order 0,1,…,7. `frameStart` is 1 exactly in the first UI of each frame.
- R2: In 4:1 mode (`ratioSel`=1) each frame is 4 UIs carrying word bits 0,1,2,3. Bits 7:4 have no effect on the output.
- R3: In 2:1 mode (`ratioSel`=2) each frame is 2 UIs carrying word bit 0 then bit 4. The other six bits have no effect, and every lane's `triOut` equals its `triIn`.
- R4: A lane whose `tsrcSel` bit is 0 drives `triOut` from its `triIn` combinationally, with no clock edge between a change of the input and the output.
- R5: A lane whose `tsrcSel` bit is 1 (in 8:1 or 4:1 mode) drives `triOut` = NOT of one enable bit per pair of UIs, starting with bit 0 for UIs 0–1. 8:1 uses bits 3:0. 4:1 uses bits 1:0, and bits 3:2 are ignored. A `triOut` of 1 means high impedance.
- R6: The `weIn` value taken at one load edge gates the data word taken at the following load edge.
- R7: Each lane uses only its selected tristate source. On a direct lane `weIn` has no effect, and on an enable lane `triIn` has no effect.
- R8: `cfgErr` is 1 when `ratioSel`=2 with any `tsrcSel` bit set, or when `ratioSel`=3. In those cases affected lanes use `triIn`, and ratio 3 serializes as 8:1.
- R9: With `preambleOn`=1, an enable lane inserts a preamble in the last UI of a frame when two conditions hold: that UI is in high impedance, and the next frame's first enable bit is 1. In that UI it drives `serOut` = bit 0 of the incoming word and `triOut`=0. With `preambleOn`=0 there is no preamble.
- R10: While `rstN` is low, `serOut` is 0, `frameStart` is 0 and enable lanes are in high impedance. The first rising edge after release loads the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ratioSel | input | 2 | Serialization ratio: 0=8:1, 1=4:1, 2=2:1, 3=reserved (runs as 8:1) |
| tsrcSel | input | LANES | Per-lane tristate source: 0=direct, 1=shared enable |
| preambleOn | input | 1 | Enables the burst preamble UI |
| dataIn | input | 8*LANES | Parallel words; lane i on bits [8i+7:8i] |
| triIn | input | LANES | Direct tristate inputs, 1=high impedance |
| weIn | input | 4 | Shared write enable, 1 bit per UI pair |
| serOut | output | LANES | Serial data per lane |
| triOut | output | LANES | Serial tristate per lane, 1=high impedance |
| frameStart | output | 1 | High in the first UI of each frame |
| cfgErr | output | 1 | Illegal ratio/source combination |

## Verification
The bench targets the following mistakes:

- **Enable latency:** enable patterns change from frame to frame and are checked against the word one frame later. A design missing the extra stage would release the pads one frame early.
- **Enable pairing:** each enable bit must span two UIs, so the pattern 0101 exposes a design that steps one UI per bit or reverses the order.
- **Bit order in 4:1 and 2:1:** words with the upper half set catch a design that sends bits 7:4 in 4:1, or bit 1 instead of bit 4 in 2:1.
- **Preamble condition:** preamble runs include a frame that is already enabled at its end, which must not get a preamble. The same runs with `preambleOn` low must show none.
- **Illegal configuration:** 2:1 with the enable source selected must raise `cfgErr` and follow `triIn`. A design without the fallback would serialize the enable or leave the pads floating.

// File: rtl/txser_pkg.sv
package txser_pkg;
  localparam int WORD_BITS = 8;
  localparam int WE_BITS   = WORD_BITS / 2;
  localparam int PH_W      = $clog2(WORD_BITS);

  typedef enum logic [1:0] {
    RATIO_8    = 2'd0,
    RATIO_4    = 2'd1,
    RATIO_2    = 2'd2,
    RATIO_RSVD = 2'd3
  } ratio_e;

  // strobes from control to every lane
  typedef struct packed {
    logic            load;          // lane word register captures this edge
    logic [PH_W-1:0] bitSel;        // word bit on the wire in this UI
    logic            weGate;        // enable bit covering this UI
    logic            preambleSlot;  // preamble condition met in this UI
    logic            mode2;         // 2:1 ratio active
  } ser_ctl_t;
endpackage

// File: rtl/txser_ctl.sv
module txser_ctl
  import txser_pkg::*;
#(
  parameter int LANES = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         ratioSel,
  input  logic [LANES-1:0]   tsrcSel,
  input  logic               preambleOn,
  input  logic [WE_BITS-1:0] weIn,
  output ser_ctl_t           ctl,
  output logic               frameStart,
  output logic               cfgErr
);
  localparam int PAIR_W = PH_W - 1;

  logic [PH_W-1:0]    ph;
  logic [PH_W-1:0]    lastPh;
  logic               mode2;
  logic               mode4;
  logic               rsvd;
  logic               loadNow;
  logic [WE_BITS-1:0] weMasked;
  logic [WE_BITS-1:0] weStage;
  logic [WE_BITS-1:0] weActive;
  logic [PAIR_W-1:0]  pairIdx;
  logic               gateNow;

  always_comb begin
    mode2  = 1'b0;
    mode4  = 1'b0;
    rsvd   = 1'b0;
    lastPh = PH_W'(WORD_BITS - 1);
    case (ratioSel)
      RATIO_8: lastPh = PH_W'(WORD_BITS - 1);
      RATIO_4: begin
        mode4  = 1'b1;
        lastPh = PH_W'(WORD_BITS / 2 - 1);
      end
      RATIO_2: begin
        mode2  = 1'b1;
        lastPh = PH_W'(1);
      end
      default: rsvd = 1'b1;
    endcase
  end

  assign loadNow = (ph >= lastPh);

  // phase counter: reset parks it on the last UI so the first edge loads
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ph <= PH_W'(WORD_BITS - 1);
    else if (loadNow) ph <= '0;
    else ph <= ph + 1'b1;
  end

  // in 4:1 only the lower half of the enable vector carries meaning
  always_comb begin
    for (int i = 0; i < WE_BITS; i++) begin
      weMasked[i] = weIn[i] & (!mode4 || (i < WE_BITS / 2));
    end
  end

  // two-stage enable pipeline: one frame later than the data words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weStage  <= '0;
      weActive <= '0;
    end else if (loadNow) begin
      weStage  <= weMasked;
      weActive <= weStage;
    end
  end

  assign pairIdx = ph[PH_W-1:1];
  assign gateNow = weActive[pairIdx];

  always_comb begin
    ctl.load         = loadNow;
    ctl.mode2        = mode2;
    ctl.bitSel       = mode2 ? {ph[0], {(PH_W - 1){1'b0}}} : ph;
    ctl.weGate       = gateNow;
    ctl.preambleSlot = preambleOn && loadNow && !mode2 && weStage[0] && !gateNow;
  end

  assign frameStart = rstN && (ph == '0);
  assign cfgErr     = rsvd || (mode2 && (|tsrcSel));
endmodule

// File: rtl/txser_lane.sv
module txser_lane
  import txser_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ser_ctl_t             ctl,
  input  logic [WORD_BITS-1:0] wordIn,
  input  logic                 triIn,
  input  logic                 weSel,
  output logic                 serOut,
  output logic                 triOut
);
  logic [WORD_BITS-1:0] wordReg;
  logic                 useWe;
  logic                 preNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wordReg <= '0;
    else if (ctl.load) wordReg <= wordIn;
  end

  // enable source is refused in 2:1; the lane then follows its own input
  assign useWe  = weSel && !ctl.mode2;
  assign preNow = useWe && ctl.preambleSlot;

  always_comb begin
    serOut = preNow ? wordIn[0] : wordReg[ctl.bitSel];
    if (!useWe) triOut = triIn;
    else if (preNow) triOut = 1'b0;
    else triOut = !ctl.weGate;
  end
endmodule

// File: rtl/txser_top.sv
module txser_top
  import txser_pkg::*;
#(
  parameter int LANES = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [1:0]                 ratioSel,
  input  logic [LANES-1:0]           tsrcSel,
  input  logic                       preambleOn,
  input  logic [LANES*WORD_BITS-1:0] dataIn,
  input  logic [LANES-1:0]           triIn,
  input  logic [WE_BITS-1:0]         weIn,
  output logic [LANES-1:0]           serOut,
  output logic [LANES-1:0]           triOut,
  output logic                       frameStart,
  output logic                       cfgErr
);
  ser_ctl_t ctl;

  txser_ctl #(.LANES(LANES)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .ratioSel   (ratioSel),
    .tsrcSel    (tsrcSel),
    .preambleOn (preambleOn),
    .weIn       (weIn),
    .ctl        (ctl),
    .frameStart (frameStart),
    .cfgErr     (cfgErr)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    txser_lane u_lane (
      .clk    (clk),
      .rstN   (rstN),
      .ctl    (ctl),
      .wordIn (dataIn[g*WORD_BITS +: WORD_BITS]),
      .triIn  (triIn[g]),
      .weSel  (tsrcSel[g]),
      .serOut (serOut[g]),
      .triOut (triOut[g])
    );
  end
endmodule

// File: rtl/txser_chk.sv
module txser_chk #(
  parameter int LANES = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       ratioSel,
  input logic [LANES-1:0] tsrcSel,
  input logic [LANES-1:0] triIn,
  input logic [LANES-1:0] triOut,
  input logic             frameStart,
  input logic             cfgErr
);
  // R1: frames are at least two UIs long
  a_r1_frame_single: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart);

  // R3: 2:1 mode leaves every pad on its direct tristate input
  a_r3_mode2_direct: assert property (@(posedge clk) disable iff (!rstN)
    (ratioSel == 2'd2) |-> (triOut == triIn));

  // R5: enable lanes hold tristate across the first UI pair
  a_r5_pair_hold: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && (ratioSel == 2'd0 || ratioSel == 2'd1))
      |=> ((triOut & tsrcSel) == ($past(triOut) & $past(tsrcSel))));

  // R7: direct lanes never take the shared enable
  a_r7_direct_lanes: assert property (@(posedge clk) disable iff (!rstN)
    (((triOut ^ triIn) & ~tsrcSel) == '0));

  // R8: enable source in 2:1 is flagged
  a_r8_illegal_flag: assert property (@(posedge clk) disable iff (!rstN)
    ((ratioSel == 2'd2) && (|tsrcSel)) |-> cfgErr);
endmodule

bind txser_top txser_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ratioSel   (ratioSel),
  .tsrcSel    (tsrcSel),
  .triIn      (triIn),
  .triOut     (triOut),
  .frameStart (frameStart),
  .cfgErr     (cfgErr)
);

// File: tb/txser_top_bench.sv
module txser_top_bench;
  localparam int LANES = 4;
  localparam int NF    = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 rstN;
  logic [1:0]           ratioSel;
  logic [LANES-1:0]     tsrcSel;
  logic                 preambleOn;
  logic [LANES*8-1:0]   dataIn;
  logic [LANES-1:0]     triIn;
  logic [3:0]           weIn;
  logic [LANES-1:0]     serOut;
  logic [LANES-1:0]     triOut;
  logic                 frameStart;
  logic                 cfgErr;

  txser_top #(.LANES(LANES)) u_txser_top (
    .clk(clk), .rstN(rstN), .ratioSel(ratioSel), .tsrcSel(tsrcSel),
    .preambleOn(preambleOn), .dataIn(dataIn), .triIn(triIn), .weIn(weIn),
    .serOut(serOut), .triOut(triOut), .frameStart(frameStart), .cfgErr(cfgErr)
  );

  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;

  logic [7:0]       dat [NF][LANES];
  logic [3:0]       wep [NF];
  logic [LANES-1:0] trp [NF];
  int nFr = 1;
  int uiPer = 8;

  task automatic check(input string tag, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic applyReset(input logic [1:0] r, input logic [LANES-1:0] s, input logic p);
    rstN = 1'b0; ratioSel = r; tsrcSel = s; preambleOn = p;
    dataIn = '1; weIn = 4'hF; triIn = 4'b0110;
    repeat (3) @(negedge clk);
    #1;
    // R10: reset state at the ports
    check("R10", "serOut in reset", int'(serOut), 0);
    check("R10", "frameStart in reset", int'(frameStart), 0);
    for (int l = 0; l < LANES; l++) begin
      check("R10", "triOut in reset", int'(triOut[l]),
            (s[l] && r != 2'd2) ? 1 : int'(triIn[l]));
    end
    rstN = 1'b1;
    uiPer = (r == 2'd1) ? 4 : (r == 2'd2) ? 2 : 8;
  endtask

  task automatic fillData(input int seed);
    for (int f = 0; f < NF; f++) begin
      wep[f] = 4'((f * 7 + seed) & 15);
      trp[f] = LANES'((f * 5 + seed * 3) & 15);
      for (int l = 0; l < LANES; l++) dat[f][l] = 8'(((f * 53 + l * 29 + seed) & 255) ^ 8'h96);
    end
  endtask

  task automatic drive(input int k);
    if (k < nFr) begin
      for (int l = 0; l < LANES; l++) dataIn[l*8 +: 8] = dat[k][l];
      weIn = wep[k]; triIn = trp[k];
    end else begin
      dataIn = '0; weIn = '0; triIn = '0;
    end
  endtask

  // runs nFr frames straight after a reset release and checks every UI
  task automatic runBurst(input string tag);
    drive(0);
    for (int f = 0; f < nFr; f++) begin
      for (int u = 0; u < uiPer; u++) begin
        logic [3:0] prevWe;
        logic       weBit;
        logic       pre;
        logic [7:0] nxt;
        int         bitIdx;
        int         expSer;
        int         expTri;
        bit         useWe;
        @(posedge clk);
        @(negedge clk);
        if (u == uiPer - 1) drive(f + 1);
        #1;
        check("R1", "frameStart", int'(frameStart), (u == 0) ? 1 : 0);
        prevWe = (f == 0) ? 4'h0 : wep[f-1];
        weBit  = prevWe[u/2];
        bitIdx = (uiPer == 2) ? u * 4 : u;
        for (int l = 0; l < LANES; l++) begin
          useWe  = tsrcSel[l] && (uiPer != 2 || ratioSel == 2'd3);
          nxt    = (f + 1 < nFr) ? dat[f+1][l] : 8'h00;
          pre    = preambleOn && useWe && (u == uiPer - 1) && wep[f][0] && !weBit;
          expSer = pre ? int'(nxt[0]) : int'(dat[f][l][bitIdx]);
          expTri = !useWe ? int'(triIn[l]) : (pre ? 0 : int'(!weBit));
          check(tag, $sformatf("serOut lane %0d frame %0d ui %0d", l, f, u), int'(serOut[l]), expSer);
          check(tag, $sformatf("triOut lane %0d frame %0d ui %0d", l, f, u), int'(triOut[l]), expTri);
        end
      end
    end
  endtask

  task automatic tOrder8;     // R1
    applyReset(2'd0, 4'b0000, 1'b0); fillData(1); nFr = 4; runBurst("R1");
  endtask

  task automatic tOrder4;     // R2: upper nibble forced to ones and to zeros
    applyReset(2'd1, 4'b0000, 1'b0); fillData(2); nFr = 4;
    for (int l = 0; l < LANES; l++) begin dat[0][l][7:4] = 4'hF; dat[1][l][7:4] = 4'h0; end
    runBurst("R2");
  endtask

  task automatic tOrder2;     // R3
    applyReset(2'd2, 4'b0000, 1'b0); fillData(3); nFr = 6;
    for (int l = 0; l < LANES; l++) begin dat[0][l] = 8'h10; dat[1][l] = 8'hEE; dat[2][l] = 8'h01; end
    runBurst("R3");
  endtask

  task automatic tComb;       // R4: no clock edge between input and output change
    applyReset(2'd0, 4'b0011, 1'b0);
    @(negedge clk);
    #2 triIn = 4'b1010; #1;
    check("R4", "triOut lanes 3:2 direct", int'(triOut[3:2]), 2);
    triIn = 4'b0101; #1;
    check("R4", "triOut lanes 3:2 direct", int'(triOut[3:2]), 1);
  endtask

  task automatic tWe8;        // R5 and R6
    applyReset(2'd0, 4'b1111, 1'b0); fillData(4); nFr = 5;
    wep[0] = 4'b1111; wep[1] = 4'b0101; wep[2] = 4'b1000; wep[3] = 4'b0000; wep[4] = 4'b0110;
    runBurst("R5");
    applyReset(2'd0, 4'b1111, 1'b0); nFr = 4;
    wep[0] = 4'b0000; wep[1] = 4'b1111; wep[2] = 4'b0000; wep[3] = 4'b1111;
    runBurst("R6");
  endtask

  task automatic tWe4;        // R5: 4:1 ignores enable bits 3:2
    applyReset(2'd1, 4'b1111, 1'b0); fillData(5); nFr = 4;
    wep[0] = 4'b1101; wep[1] = 4'b1110; wep[2] = 4'b0011; wep[3] = 4'b1100;
    runBurst("R5");
  endtask

  task automatic tMixed;      // R7
    applyReset(2'd0, 4'b0101, 1'b0); fillData(6); nFr = 5;
    runBurst("R7");
  endtask

  task automatic tPreamble;   // R9, with and without preamble
    for (int pass = 0; pass < 2; pass++) begin
      applyReset(2'd0, 4'b1111, pass == 0); fillData(7); nFr = 5;
      wep[0] = 4'b1111; wep[1] = 4'b0001; wep[2] = 4'b0111; wep[3] = 4'b0000; wep[4] = 4'b0001;
      runBurst("R9");
    end
    applyReset(2'd1, 4'b0110, 1'b1); fillData(8); nFr = 4;
    wep[0] = 4'b0001; wep[1] = 4'b0000; wep[2] = 4'b0011; wep[3] = 4'b0001;
    runBurst("R9");
  endtask

  task automatic tIllegal;    // R8
    applyReset(2'd2, 4'b1111, 1'b1); #1;
    check("R8", "cfgErr 2:1 with enable source", int'(cfgErr), 1);
    fillData(9); nFr = 4; runBurst("R8");
    applyReset(2'd3, 4'b0000, 1'b0); #1;
    check("R8", "cfgErr reserved ratio", int'(cfgErr), 1);
    fillData(10); nFr = 3; runBurst("R8");
    applyReset(2'd0, 4'b1111, 1'b0); #1;
    check("R8", "cfgErr legal", int'(cfgErr), 0);
    applyReset(2'd2, 4'b0000, 1'b0); #1;
    check("R8", "cfgErr 2:1 direct", int'(cfgErr), 0);
  endtask

  initial begin
    tOrder8();
    tOrder4();
    tOrder2();
    tComb();
    tWe8();
    tWe4();
    tMixed();
    tPreamble();
    tIllegal();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end
endmodule